// File: doc/BRIEF.md
# IDE Register Window Decoder

This block sits behind the programmed-I/O path of a two-channel IDE controller. Five address windows (primary command, primary control, secondary command, secondary control and bus-master) each have a base that a configuration port loads. Every host access is compared against the enabled windows. The hit is translated into an offset within one shared 40-byte register file, and the access is then checked for legal width and placement before it is allowed to read or change that file.

Writes to the command byte of either channel are special. The decoder works out the target drive from the channel and the drive-select byte. It refuses the command if that drive is absent or still busy. Otherwise it stores the byte twice (command location and alternate status location), marks the drive busy and fires a one-cycle start strobe toward it. Each drive reports completion on its done input, which clears its busy flag. Any refused access raises a sticky error flag and leaves all state untouched.

Accesses are accepted in every cycle with no back-pressure. A read returns its data on `rd_data` with `rd_valid` high in the cycle after the access is presented. Configuration, drive and error pins are plain level or pulse signals.

Top module: `ide_pio_decode`

## Requirements
- R1: After reset every window base is zero and every window is disabled, so any access before its window is configured is an access error. `drv_busy`, `drv_start` and `err` are 0 and every register byte reads 0.
- R2: Window index `cfg_sel` 0..4 selects primary command (8 bytes, file offset 0x00), primary control (4 bytes, 0x08), secondary command (8 bytes, 0x0C), secondary control (4 bytes, 0x14) and bus-master (16 bytes, 0x18). An address A with base <= A < base+length maps to file offset internal_base + (A - base). When windows overlap, the lowest window index wins.
- R3: An enabled access whose address hits no window sets `err`.
- R4: While `io_en` is 0, writes change nothing, reads return 0, no command starts and `err` does not change.
- R5: `acc_size` gives the access width in bytes. Only 1, 2 and 4 are legal. A run that would pass byte 39 of the file is also illegal. Both cases set `err`.
- R6: Writes are little-endian: byte k of `acc_wdata` goes to offset+k. A read returns bytes offset..offset+size-1 in bits 8k+7..8k, with the upper bits zero. `rd_valid` is high one cycle after any read is presented.
- R7: A write to a command block's data register (window offset 0) must be 2 bytes wide. Any other width sets `err`.
- R8: A write to a command block's command register (window offset 7) must be 1 byte wide. Any other width sets `err`.
- R9: The target drive is 2*channel + bit 4 of that channel's drive-select byte (window offset 6). Channel 0 is the primary command window and channel 1 is the secondary one.
- R10: An accepted command write stores the byte at the command location and at the location 3 bytes above it. It sets that drive's `drv_busy` bit and pulses that drive's `drv_start` bit high for exactly the one cycle after the write.
- R11: A command write to a drive whose `drv_present` bit is 0, or whose `drv_busy` bit is 1, sets `err`, stores nothing and starts nothing.
- R12: `drv_done[i]` high for one cycle clears `drv_busy[i]` in the next cycle.
- R13: `err` stays 1 until reset once set, and any access that sets it changes no register byte and no busy flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_en | input | 1 | I/O-space enable; accesses are ignored while low |
| cfg_we | input | 1 | Load strobe for a window base |
| cfg_sel | input | 3 | Window index to load (0..4; others ignored) |
| cfg_base | input | AW | Base address to load; also enables the window |
| acc_valid | input | 1 | Host access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | AW | Host I/O address |
| acc_size | input | 3 | Access width in bytes |
| acc_wdata | input | 32 | Write data, little-endian |
| rd_valid | output | 1 | Read data valid (one cycle after a read) |
| rd_data | output | 32 | Read data |
| drv_present | input | 4 | Drive i is attached |
| drv_done | input | 4 | Drive i finished its command |
| drv_start | output | 4 | One-cycle command start per drive |
| drv_busy | output | 4 | Drive i has a command in flight |
| err | output | 1 | Sticky access error |

## Verification
The bench builds the block with its default 16-bit address width and places the five windows apart, plus one deliberately overlapping pair. At that size a sweep can write and read back every one of the 40 register bytes through its own window, and can read every legal 2- and 4-byte run, with expected bytes taken from an arithmetic shadow of the file. All four drives are commanded through both channels and both select values. Each refusal case runs from a fresh reset, so the sticky flag and the unchanged state can be attributed to one access.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

  localparam int NUM_WIN    = 5;
  localparam int FILE_BYTES = 40;
  localparam int NUM_DRV    = 4;
  localparam int DRV_W      = $clog2(NUM_DRV);
  localparam int OFS_W      = $clog2(FILE_BYTES + 1);
  localparam int REL_W      = 4;

  // offsets inside a command block
  localparam int CB_DATA  = 0;
  localparam int CB_SEL   = 6;
  localparam int CB_CMD   = 7;
  localparam int ALT_GAP  = 3;
  localparam int SEL_BIT  = 4;

  typedef enum logic [2:0] {
    WIN_PCMD = 3'd0,
    WIN_PCTL = 3'd1,
    WIN_SCMD = 3'd2,
    WIN_SCTL = 3'd3,
    WIN_BM   = 3'd4
  } win_e;

  function automatic int win_ofs(input int w);
    case (w)
      0:       return 'h00;
      1:       return 'h08;
      2:       return 'h0C;
      3:       return 'h14;
      default: return 'h18;
    endcase
  endfunction

  function automatic int win_len(input int w);
    case (w)
      0, 2:    return 8;
      1, 3:    return 4;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/ide_win_match.sv
module ide_win_match
  import ide_pio_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_sel,
  input  logic [AW-1:0]        cfg_base,
  input  logic [AW-1:0]        addr,
  output logic                 hit,
  output win_e                 win,
  output logic [REL_W-1:0]     rel,
  output logic [OFS_W-1:0]     ofs
);

  logic [NUM_WIN-1:0] hit_v;
  logic [REL_W-1:0]   rel_v [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [AW-1:0] base_q;
    logic          en_q;
    logic [AW:0]   diff;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q <= '0;
        en_q   <= 1'b0;
      end else if (cfg_we && cfg_sel == 3'(w)) begin
        base_q <= cfg_base;
        en_q   <= 1'b1;
      end
    end

    always_comb begin
      diff     = {1'b0, addr} - {1'b0, base_q};
      hit_v[w] = en_q && (addr >= base_q) && (diff < (AW+1)'(win_len(w)));
      rel_v[w] = diff[REL_W-1:0];
    end
  end

  // lowest index wins: scan from the top so lower windows overwrite
  always_comb begin
    hit = 1'b0;
    win = WIN_PCMD;
    rel = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit_v[w]) begin
        hit = 1'b1;
        win = win_e'(w);
        rel = rel_v[w];
      end
    end
    ofs = OFS_W'(win_ofs(int'(win))) + OFS_W'(rel);
  end

endmodule

// File: rtl/ide_regfile.sv
module ide_regfile
  import ide_pio_pkg::*;
#(
  parameter int BYTES = FILE_BYTES,
  parameter int OW    = OFS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [OW-1:0] wr_ofs,
  input  logic [2:0]    wr_size,
  input  logic [31:0]   wr_data,
  input  logic          mir_en,
  input  logic [OW-1:0] mir_ofs,
  input  logic [7:0]    mir_byte,
  input  logic [OW-1:0] rd_ofs,
  output logic [31:0]   rd_word,
  output logic [7:0]    sel0_byte,
  output logic [7:0]    sel1_byte
);

  localparam int SEL0 = win_ofs(0) + CB_SEL;
  localparam int SEL1 = win_ofs(2) + CB_SEL;

  logic [7:0] mem [BYTES];

  for (genvar i = 0; i < BYTES; i++) begin : g_byte
    logic [OW-1:0] rel;
    logic          in_run;

    always_comb begin
      rel    = OW'(i) - wr_ofs;
      in_run = wr_en && (OW'(i) >= wr_ofs) && (rel < OW'(wr_size));
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (in_run)
        mem[i] <= wr_data[8*rel[1:0] +: 8];
      else if (mir_en && mir_ofs == OW'(i))
        mem[i] <= mir_byte;
    end
  end

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      int idx;
      idx = int'(rd_ofs) + k;
      rd_word[8*k +: 8] = (idx < BYTES) ? mem[idx] : 8'h00;
    end
  end

  assign sel0_byte = mem[SEL0];
  assign sel1_byte = mem[SEL1];

endmodule

// File: rtl/ide_cmd_dispatch.sv
module ide_cmd_dispatch #(
  parameter int NDRV = 4,
  parameter int IW   = $clog2(NDRV)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic [IW-1:0]   idx,
  input  logic [NDRV-1:0] done,
  output logic [NDRV-1:0] busy,
  output logic [NDRV-1:0] start
);

  for (genvar d = 0; d < NDRV; d++) begin : g_drv
    logic busy_q;
    logic start_q;
    logic pick;

    assign pick = fire && (idx == IW'(d));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_q  <= 1'b0;
        start_q <= 1'b0;
      end else begin
        start_q <= pick;
        if (pick)
          busy_q <= 1'b1;
        else if (done[d])
          busy_q <= 1'b0;
      end
    end

    assign busy[d]  = busy_q;
    assign start[d] = start_q;
  end

endmodule

// File: rtl/ide_pio_decode.sv
module ide_pio_decode
  import ide_pio_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               io_en,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_sel,
  input  logic [AW-1:0]      cfg_base,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [AW-1:0]      acc_addr,
  input  logic [2:0]         acc_size,
  input  logic [31:0]        acc_wdata,
  output logic               rd_valid,
  output logic [31:0]        rd_data,
  input  logic [NUM_DRV-1:0] drv_present,
  input  logic [NUM_DRV-1:0] drv_done,
  output logic [NUM_DRV-1:0] drv_start,
  output logic [NUM_DRV-1:0] drv_busy,
  output logic               err
);

  logic             hit;
  win_e             win;
  logic [REL_W-1:0] rel;
  logic [OFS_W-1:0] ofs;

  ide_win_match #(.AW(AW)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_base (cfg_base),
    .addr     (acc_addr),
    .hit      (hit),
    .win      (win),
    .rel      (rel),
    .ofs      (ofs)
  );

  // access classification
  logic             size_ok, in_file, cmd_blk, data_reg, cmd_reg;
  logic             chan;
  logic [7:0]       sel0_byte, sel1_byte, sel_byte;
  logic [DRV_W-1:0] drv;
  logic             bad, active, good_wr, fire;
  logic [31:0]      rd_word, rd_mask;

  always_comb begin
    size_ok  = (acc_size == 3'd1) || (acc_size == 3'd2) || (acc_size == 3'd4);
    in_file  = ({1'b0, ofs} + (OFS_W+1)'(acc_size)) <= (OFS_W+1)'(FILE_BYTES);
    cmd_blk  = (win == WIN_PCMD) || (win == WIN_SCMD);
    data_reg = cmd_blk && (rel == REL_W'(CB_DATA));
    cmd_reg  = cmd_blk && (rel == REL_W'(CB_CMD));
    chan     = (win == WIN_SCMD);
    sel_byte = chan ? sel1_byte : sel0_byte;
    drv      = {chan, sel_byte[SEL_BIT]};

    bad = !hit || !size_ok || !in_file;
    if (acc_write && data_reg && acc_size != 3'd2)
      bad = 1'b1;
    if (acc_write && cmd_reg &&
        (acc_size != 3'd1 || drv_busy[drv] || !drv_present[drv]))
      bad = 1'b1;

    active  = acc_valid && io_en;
    good_wr = active && acc_write && !bad;
    fire    = good_wr && cmd_reg;

    case (acc_size)
      3'd1:    rd_mask = 32'h0000_00FF;
      3'd2:    rd_mask = 32'h0000_FFFF;
      default: rd_mask = 32'hFFFF_FFFF;
    endcase
  end

  ide_regfile #(.BYTES(FILE_BYTES), .OW(OFS_W)) u_file (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (good_wr),
    .wr_ofs    (ofs),
    .wr_size   (acc_size),
    .wr_data   (acc_wdata),
    .mir_en    (fire),
    .mir_ofs   (ofs + OFS_W'(ALT_GAP)),
    .mir_byte  (acc_wdata[7:0]),
    .rd_ofs    (ofs),
    .rd_word   (rd_word),
    .sel0_byte (sel0_byte),
    .sel1_byte (sel1_byte)
  );

  ide_cmd_dispatch #(.NDRV(NUM_DRV), .IW(DRV_W)) u_disp (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .idx   (drv),
    .done  (drv_done),
    .busy  (drv_busy),
    .start (drv_start)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      err      <= 1'b0;
    end else begin
      rd_valid <= acc_valid && !acc_write;
      if (acc_valid && !acc_write)
        rd_data <= (active && !bad) ? (rd_word & rd_mask) : 32'h0;
      if (active && bad)
        err <= 1'b1;
    end
  end

endmodule

// File: rtl/ide_pio_decode_chk.sv
module ide_pio_decode_chk
  import ide_pio_pkg::*;
#(
  parameter int AW = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               io_en,
  input logic               cfg_we,
  input logic [2:0]         cfg_sel,
  input logic [AW-1:0]      cfg_base,
  input logic               acc_valid,
  input logic               acc_write,
  input logic [AW-1:0]      acc_addr,
  input logic [2:0]         acc_size,
  input logic [31:0]        acc_wdata,
  input logic               rd_valid,
  input logic [31:0]        rd_data,
  input logic [NUM_DRV-1:0] drv_present,
  input logic [NUM_DRV-1:0] drv_done,
  input logic [NUM_DRV-1:0] drv_start,
  input logic [NUM_DRV-1:0] drv_busy,
  input logic               err
);

  // R10
  start_marks_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_start & ~drv_busy) == '0);

  // R10
  start_one_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drv_start));

  // R10
  start_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|drv_start) |=> ((drv_start & $past(drv_start)) == '0));

  // R12
  done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(drv_busy & drv_done)) |=> ((drv_busy & $past(drv_busy & drv_done)) == '0));

  // R13
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R4
  io_off_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_en && !err) |=> (drv_start == '0 && !err));

  // R4
  io_off_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && !io_en) |=> (rd_data == 32'h0));

  // R6
  read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> rd_valid);

endmodule

bind ide_pio_decode ide_pio_decode_chk #(.AW(AW)) u_chk (.*);

// File: tb/ide_pio_decode_test.sv
module ide_pio_decode_test;

  localparam int AW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_en = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [AW-1:0] cfg_base = '0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [2:0]  acc_size = 3'd1;
  logic [31:0] acc_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [3:0]  drv_present = 4'hF;
  logic [3:0]  drv_done = '0;
  logic [3:0]  drv_start;
  logic [3:0]  drv_busy;
  logic        err;

  int tests = 0;
  int fails = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  ide_pio_decode #(.AW(AW)) uut (.*);

  // window layout used by the bench
  int wbase [5] = '{'h01F0, 'h03F4, 'h0170, 'h0374, 'hC000};
  logic [7:0] mdl [40];

  function automatic int iofs(int w);
    case (w) 0: return 'h00; 1: return 'h08; 2: return 'h0C; 3: return 'h14; default: return 'h18; endcase
  endfunction
  function automatic int ilen(int w);
    case (w) 0, 2: return 8; 1, 3: return 4; default: return 16; endcase
  endfunction
  function automatic logic [31:0] mdl_word(int o, int sz);
    logic [31:0] v = '0;
    for (int k = 0; k < sz; k++) v[8*k +: 8] = mdl[o+k];
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic cfg(input int sel, input int base);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_base = AW'(base);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic acc(input bit wr, input int addr, input int sz, input logic [31:0] wd,
                     output logic [31:0] rd, output logic [3:0] st);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = AW'(addr);
    acc_size = 3'(sz); acc_wdata = wd;
    @(posedge clk); #1;
    rd = rd_data; st = drv_start;
    acc_valid = 1'b0;
  endtask

  task automatic fresh(input bit with_cfg);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < 40; i++) mdl[i] = 8'h00;
    if (with_cfg) for (int w = 0; w < 5; w++) cfg(w, wbase[w]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic [3:0]  st;

    // ---------- R1: reset state, windows disabled ----------
    fresh(1'b0);
    chk("R1 err at reset", 32'(err), 0);
    chk("R1 busy at reset", 32'(drv_busy), 0);
    chk("R1 start at reset", 32'(drv_start), 0);
    acc(0, 'h0000, 1, 0, rd, st);
    chk("R1 unconfigured window errs", 32'(err), 1);
    chk("R1 read of unconfigured window", rd, 0);

    // ---------- R2/R6/R7: sweep every register byte ----------
    fresh(1'b1);
    for (int w = 0; w < 5; w++) begin
      for (int r = 0; r < ilen(w); r++) begin
        int o;
        int a;
        logic [7:0] v;
        o = iofs(w) + r;
        a = wbase[w] + r;
        v = 8'((o * 7 + 'h31) & 'hFF);
        if ((w == 0 || w == 2) && r == 7) continue;
        if ((w == 0 || w == 2) && r == 0) begin
          acc(1, a, 2, {16'h0, v, ~v}, rd, st);
          mdl[o] = ~v; mdl[o+1] = v;
          acc(0, a, 2, 0, rd, st);
          chk("R7 data register 16-bit write", rd, mdl_word(o, 2));
        end else begin
          acc(1, a, 1, {24'h0, v}, rd, st);
          mdl[o] = v;
          acc(0, a, 1, 0, rd, st);
          chk("R2 byte maps to window offset", rd, mdl_word(o, 1));
          chk("R6 rd_valid after read", 32'(rd_valid), 1);
        end
      end
    end
    chk("R2 sweep left err clear", 32'(err), 0);

    // R6: wider reads everywhere a run fits
    for (int w = 0; w < 5; w++) begin
      for (int r = 0; r < ilen(w); r++) begin
        int o;
        o = iofs(w) + r;
        if (o + 2 <= 40) begin
          acc(0, wbase[w] + r, 2, 0, rd, st);
          chk("R6 16-bit read", rd, mdl_word(o, 2));
        end
        if (o + 4 <= 40) begin
          acc(0, wbase[w] + r, 4, 0, rd, st);
          chk("R6 32-bit read", rd, mdl_word(o, 4));
        end
      end
    end
    // R6: 32-bit little-endian write
    acc(1, wbase[4] + 4, 4, 32'hA1B2C3D4, rd, st);
    mdl['h1C] = 8'hD4; mdl['h1D] = 8'hC3; mdl['h1E] = 8'hB2; mdl['h1F] = 8'hA1;
    for (int k = 0; k < 4; k++) begin
      acc(0, wbase[4] + 4 + k, 1, 0, rd, st);
      chk("R6 little-endian byte lane", rd, mdl_word('h1C + k, 1));
    end

    // ---------- R9/R10: command to each drive ----------
    for (int d = 0; d < 4; d++) begin
      int ch;
      int cb;
      int ctl;
      int oc;
      logic [7:0] c;
      ch  = d >> 1;
      cb  = ch ? wbase[2] : wbase[0];
      ctl = ch ? wbase[3] : wbase[1];
      oc  = (ch ? 'h0C : 'h00) + 7;
      c   = 8'('h90 + d);
      acc(1, cb + 6, 1, 32'((d & 1) << 4), rd, st);
      mdl[oc-1] = 8'((d & 1) << 4);
      acc(1, cb + 7, 1, {24'h0, c}, rd, st);
      chk("R9 start goes to selected drive", 32'(st), 32'(1 << d));
      chk("R10 busy set for drive", 32'(drv_busy[d]), 1);
      @(posedge clk); #1;
      chk("R10 start lasts one cycle", 32'(drv_start), 0);
      mdl[oc] = c; mdl[oc+3] = c;
      acc(0, cb + 7, 1, 0, rd, st);
      chk("R10 command byte stored", rd, 32'(c));
      acc(0, ctl + 2, 1, 0, rd, st);
      chk("R10 mirrored 3 bytes above", rd, 32'(c));
    end
    chk("R10 all drives busy", 32'(drv_busy), 'hF);
    chk("R10 no error on commands", 32'(err), 0);

    // ---------- R12: done clears busy ----------
    @(negedge clk); drv_done = 4'b0101;
    @(posedge clk); #1; drv_done = 4'b0000;
    chk("R12 done clears busy", 32'(drv_busy), 'hA);
    @(negedge clk); drv_done = 4'b1010;
    @(posedge clk); #1; drv_done = 4'b0000;
    chk("R12 done clears remaining", 32'(drv_busy), 0);

    // ---------- R4: I/O space disabled ----------
    io_en = 1'b0;
    acc(1, wbase[0] + 1, 1, 32'hEE, rd, st);
    acc(0, wbase[0] + 1, 1, 0, rd, st);
    chk("R4 read returns zero when disabled", rd, 0);
    acc(1, wbase[0] + 7, 1, 32'h20, rd, st);
    chk("R4 no start when disabled", 32'(st), 0);
    chk("R4 no busy when disabled", 32'(drv_busy), 0);
    acc(1, 'h0800, 3, 0, rd, st);
    chk("R4 no error when disabled", 32'(err), 0);
    io_en = 1'b1;
    acc(0, wbase[0] + 1, 1, 0, rd, st);
    chk("R4 write was ignored", rd, mdl_word(1, 1));

    // ---------- R3: miss ----------
    fresh(1'b1);
    acc(1, 'h0800, 1, 32'h5A, rd, st);
    chk("R3 miss sets err", 32'(err), 1);
    acc(0, 'h0800, 1, 0, rd, st);
    chk("R3 miss reads zero", rd, 0);

    // ---------- R5: bad sizes ----------
    fresh(1'b1);
    acc(1, wbase[0] + 1, 3, 32'h112233, rd, st);
    chk("R5 size 3 sets err", 32'(err), 1);
    acc(0, wbase[0] + 1, 2, 0, rd, st);
    chk("R13 size 3 write changed nothing", rd, 0);
    fresh(1'b1);
    acc(1, wbase[0] + 2, 0, 32'h77, rd, st);
    chk("R5 size 0 sets err", 32'(err), 1);
    fresh(1'b1);
    acc(1, wbase[4] + 14, 4, 32'hDEADBEEF, rd, st);
    chk("R5 run past file end sets err", 32'(err), 1);
    acc(0, wbase[4] + 14, 2, 0, rd, st);
    chk("R13 overrun write changed nothing", rd, 0);

    // ---------- R7/R8: register width rules ----------
    fresh(1'b1);
    acc(1, wbase[0], 1, 32'h77, rd, st);
    chk("R7 8-bit data write sets err", 32'(err), 1);
    acc(0, wbase[0], 2, 0, rd, st);
    chk("R7 data register unchanged", rd, 0);
    fresh(1'b1);
    acc(1, wbase[2] + 7, 2, 32'h0030, rd, st);
    chk("R8 16-bit command write sets err", 32'(err), 1);
    chk("R8 no start", 32'(st), 0);
    acc(0, wbase[2] + 7, 1, 0, rd, st);
    chk("R8 command byte unchanged", rd, 0);

    // ---------- R11: absent and busy drives ----------
    fresh(1'b1);
    drv_present = 4'b1110;
    acc(1, wbase[0] + 7, 1, 32'hC8, rd, st);
    chk("R11 absent drive sets err", 32'(err), 1);
    chk("R11 absent drive not started", 32'(st), 0);
    chk("R11 absent drive not busy", 32'(drv_busy), 0);
    acc(0, wbase[1] + 2, 1, 0, rd, st);
    chk("R11 nothing mirrored", rd, 0);
    drv_present = 4'hF;
    fresh(1'b1);
    acc(1, wbase[2] + 6, 1, 32'h10, rd, st);
    acc(1, wbase[2] + 7, 1, 32'h25, rd, st);
    chk("R9 channel 1 select bit picks drive 3", 32'(st), 'h8);
    acc(1, wbase[2] + 7, 1, 32'h35, rd, st);
    chk("R11 busy drive sets err", 32'(err), 1);
    chk("R11 busy drive not restarted", 32'(st), 0);
    acc(0, wbase[2] + 7, 1, 0, rd, st);
    chk("R11 first command kept", rd, 'h25);

    // ---------- R13: sticky ----------
    acc(1, wbase[4], 1, 32'h01, rd, st);
    acc(0, wbase[4], 1, 0, rd, st);
    chk("R13 good access still works", rd, 1);
    chk("R13 err stays set", 32'(err), 1);

    // ---------- R2: overlap priority ----------
    fresh(1'b0);
    cfg(0, 'h0100);
    cfg(1, 'h0104);
    acc(1, 'h0105, 1, 32'h6B, rd, st);
    cfg(0, 'h0200);
    acc(0, 'h0205, 1, 0, rd, st);
    chk("R2 overlap went to lower window", rd, 'h6B);
    acc(0, 'h0105, 1, 0, rd, st);
    chk("R2 higher window untouched", rd, 0);
    chk("R2 overlap no err", 32'(err), 0);

    finish_run();
  end

endmodule